// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank With Wakeup

This block is a bank of 32 general-purpose pins behind a word-wide register interface. Any pin whose direction bit marks it as an input is watched by four independent detectors: low level, high level, rising edge and falling edge. Each input is passed through a two-stage synchronizer first. A qualifying event latches the pin's bit in two separate sticky status words. Each status word has its own enable word and drives its own interrupt line. A qualifying event can also raise a one-cycle wakeup request when the bank is configured for it.

Software owns the bank through single-cycle register writes with byte enables and through combinational reads. The enable words, the wakeup-enable word and the output data word also have set and clear alias addresses, so single bits can be changed without a read-modify-write. Setting bit 1 of the configuration register resets the bank. The debounce enable and debounce time registers are plain storage and have no timing function.

There is no controlling state machine. The bank is a register file, a detection datapath and two OR-reduced interrupt outputs.

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset, offset 0x34 (direction, 1 = input) reads 0xFFFFFFFF and 0x30 (control) reads 2. Status 1 (0x18), status 2 (0x28), enable 1 (0x1C), enable 2 (0x2C), wakeup enable (0x20), all four detector words and both debounce registers read 0. Offset 0x14 reads 1, offset 0x00 reads the REVISION parameter, and irq_a, irq_b and wake_req are low.
- R2: Only pins whose direction bit is 1 raise events. Every event sets the pin's bit in both status 1 and status 2.
- R3: Edge events are taken on the synchronized input. Rise-detect (0x48) bit n fires on a 0-to-1 change of pin n and fall-detect (0x4C) bit n fires on a 1-to-0 change. Status is visible on the third rising clock edge after the pin changes.
- R4: High-level detect (0x44) and low-level detect (0x40) fire on every cycle the input sits at that level. A status bit cleared while its level persists reads as set again.
- R5: Writing 1 to a bit of a status register clears that bit. Writing 0 leaves it unchanged, and each status register is cleared independently.
- R6: irq_a is high exactly when status 1 AND enable 1 is nonzero. irq_b follows status 2 and enable 2 in the same way, independently of irq_a.
- R7: The following alias pairs act on a base register, clear first and set second: 0x60/0x64 on enable 1, 0x70/0x74 on enable 2, 0x80/0x84 on wakeup enable, and 0x90/0x94 on data out (0x3C). A clear write ANDs the base with the complement of the data and a set write ORs the data in. Reading an alias returns its base register.
- R8: wake_req pulses in the cycle a status bit latches, but only when configuration (0x10) bit 2 is 1, configuration bits 4:3 are nonzero, and the pin's wakeup-enable bit is 1.
- R9: A write to 0x10 stores the data ANDed with 0x1D. If bit 1 of the data is 1, the write also returns every register to its R1 value, except the data-out word and the stored configuration.
- R10: On ordinary registers a byte-enable bit replaces that byte lane and the other lanes keep their old value. On status, set and clear addresses the disabled lanes are treated as zero.
- R11: pin_out equals the data-out word and pin_drive is the complement of the direction word. Offset 0x38 reads the synchronized pins. Writes to 0x00, 0x14 and 0x38 are ignored.
- R12: Control keeps only bits 2:0 and debounce time keeps only bits 7:0. Debounce enable keeps all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data, already lane-aligned |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Data-out word |
| pin_drive | output | 32 | High where the pin is an output |
| irq_a | output | 1 | Interrupt line 1 |
| irq_b | output | 1 | Interrupt line 2 |
| wake_req | output | 1 | One-cycle wakeup request |

## Verification
On every cycle, the assertions check four things. A full zero write to an enable word drops its interrupt line on the next cycle. wake_req is never raised unless the configuration qualified it in the previous cycle. Newly latched status bits belong only to pins that were inputs. Any bit that appears in status 1 is also present in status 2. The bench scenarios cover the rest: edge timing through the synchronizer, level re-latch after a clear, alias arithmetic, byte-lane merging versus non-merging, soft-reset reach and field truncation. Each of these needs a chosen sequence of writes and pin moves followed by reads.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int REG_W   = 32;
    localparam int LANES   = REG_W / 8;

    localparam logic [7:0] A_REV    = 8'h00;
    localparam logic [7:0] A_CFG    = 8'h10;
    localparam logic [7:0] A_SSTAT  = 8'h14;
    localparam logic [7:0] A_ST1    = 8'h18;
    localparam logic [7:0] A_EN1    = 8'h1C;
    localparam logic [7:0] A_WEN    = 8'h20;
    localparam logic [7:0] A_ST2    = 8'h28;
    localparam logic [7:0] A_EN2    = 8'h2C;
    localparam logic [7:0] A_CTRL   = 8'h30;
    localparam logic [7:0] A_DIR    = 8'h34;
    localparam logic [7:0] A_DIN    = 8'h38;
    localparam logic [7:0] A_DOUT   = 8'h3C;
    localparam logic [7:0] A_LLO    = 8'h40;
    localparam logic [7:0] A_LHI    = 8'h44;
    localparam logic [7:0] A_RISE   = 8'h48;
    localparam logic [7:0] A_FALL   = 8'h4C;
    localparam logic [7:0] A_DBEN   = 8'h50;
    localparam logic [7:0] A_DBT    = 8'h54;
    localparam logic [7:0] A_EN1C   = 8'h60;
    localparam logic [7:0] A_EN1S   = 8'h64;
    localparam logic [7:0] A_EN2C   = 8'h70;
    localparam logic [7:0] A_EN2S   = 8'h74;
    localparam logic [7:0] A_WENC   = 8'h80;
    localparam logic [7:0] A_WENS   = 8'h84;
    localparam logic [7:0] A_DOUTC  = 8'h90;
    localparam logic [7:0] A_DOUTS  = 8'h94;

    localparam logic [7:0] CFG_KEEP = 8'h1D;
    localparam int         CFG_SRST = 1;
    localparam int         CFG_WKEN = 2;
    localparam logic [2:0] CTRL_RST = 3'd2;

    function automatic logic [REG_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [REG_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= d_async;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_now,
    input  logic [WIDTH-1:0] is_input,
    input  logic [WIDTH-1:0] sel_low,
    input  logic [WIDTH-1:0] sel_high,
    input  logic [WIDTH-1:0] sel_rise,
    input  logic [WIDTH-1:0] sel_fall,
    output logic [WIDTH-1:0] event_vec
);
    logic [WIDTH-1:0] level_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_prev <= '0;
        else        level_prev <= level_now;
    end

    always_comb begin
        event_vec = is_input & ( (sel_high &  level_now)
                               | (sel_low  & ~level_now)
                               | (sel_rise &  level_now & ~level_prev)
                               | (sel_fall & ~level_now &  level_prev));
    end
endmodule

// File: rtl/gpio_wake_bank.sv
module gpio_wake_bank
    import gpb_pkg::*;
#(
    parameter logic [7:0] REVISION    = 8'h21,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  pin_in,
    output logic [REG_W-1:0]  pin_out,
    output logic [REG_W-1:0]  pin_drive,
    output logic              irq_a,
    output logic              irq_b,
    output logic              wake_req
);
    logic [7:0]       cfg_q;
    logic [REG_W-1:0] stat_a, stat_b, en_a, en_b, wen_q, dir_q, dout_q;
    logic [REG_W-1:0] llo_q, lhi_q, rise_q, fall_q, dben_q;
    logic [7:0]       dbt_q;
    logic [2:0]       ctrl_q;

    logic [REG_W-1:0] pin_s, evt;
    logic [REG_W-1:0] bmask, cur, merged, w1v;
    logic             soft_rst;

    gpb_sync #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(pin_s)
    );

    gpb_detect #(.WIDTH(REG_W)) u_det (
        .clk(clk), .rst_n(rst_n), .level_now(pin_s), .is_input(dir_q),
        .sel_low(llo_q), .sel_high(lhi_q), .sel_rise(rise_q), .sel_fall(fall_q),
        .event_vec(evt)
    );

    function automatic logic hit(input logic [7:0] a, input logic [7:0] off);
        return a == off;
    endfunction

    always_comb begin
        unique case (bus_addr)
            A_REV:                cur = {{(REG_W-8){1'b0}}, REVISION};
            A_CFG:                cur = {{(REG_W-8){1'b0}}, cfg_q};
            A_SSTAT:              cur = {{(REG_W-1){1'b0}}, 1'b1};
            A_ST1:                cur = stat_a;
            A_ST2:                cur = stat_b;
            A_EN1, A_EN1C, A_EN1S: cur = en_a;
            A_EN2, A_EN2C, A_EN2S: cur = en_b;
            A_WEN, A_WENC, A_WENS: cur = wen_q;
            A_CTRL:               cur = {{(REG_W-3){1'b0}}, ctrl_q};
            A_DIR:                cur = dir_q;
            A_DIN:                cur = pin_s;
            A_DOUT, A_DOUTC, A_DOUTS: cur = dout_q;
            A_LLO:                cur = llo_q;
            A_LHI:                cur = lhi_q;
            A_RISE:               cur = rise_q;
            A_FALL:               cur = fall_q;
            A_DBEN:               cur = dben_q;
            A_DBT:                cur = {{(REG_W-8){1'b0}}, dbt_q};
            default:              cur = '0;
        endcase
        bmask    = lane_mask(bus_be);
        merged   = (cur & ~bmask) | (bus_wdata & bmask);
        w1v      = bus_wdata & bmask;
        soft_rst = bus_wr && hit(bus_addr, A_CFG) && merged[CFG_SRST];
    end

    assign bus_rdata = cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;  stat_a <= '0; stat_b <= '0; en_a <= '0; en_b <= '0;
            wen_q <= '0;  dir_q <= '1;  dout_q <= '0; llo_q <= '0; lhi_q <= '0;
            rise_q <= '0; fall_q <= '0; dben_q <= '0; dbt_q <= '0;
            ctrl_q <= CTRL_RST; wake_req <= 1'b0;
        end else if (soft_rst) begin
            cfg_q <= merged[7:0] & CFG_KEEP;
            stat_a <= '0; stat_b <= '0; en_a <= '0; en_b <= '0; wen_q <= '0;
            dir_q <= '1;  llo_q <= '0;  lhi_q <= '0; rise_q <= '0; fall_q <= '0;
            dben_q <= '0; dbt_q <= '0;  ctrl_q <= CTRL_RST; wake_req <= 1'b0;
        end else begin
            stat_a <= (stat_a & ~((bus_wr && hit(bus_addr, A_ST1)) ? w1v : '0)) | evt;
            stat_b <= (stat_b & ~((bus_wr && hit(bus_addr, A_ST2)) ? w1v : '0)) | evt;
            wake_req <= cfg_q[CFG_WKEN] && (|cfg_q[4:3]) && (|(evt & wen_q));
            if (bus_wr) begin
                unique case (bus_addr)
                    A_CFG:   cfg_q  <= merged[7:0] & CFG_KEEP;
                    A_EN1:   en_a   <= merged;
                    A_EN1C:  en_a   <= en_a & ~w1v;
                    A_EN1S:  en_a   <= en_a | w1v;
                    A_EN2:   en_b   <= merged;
                    A_EN2C:  en_b   <= en_b & ~w1v;
                    A_EN2S:  en_b   <= en_b | w1v;
                    A_WEN:   wen_q  <= merged;
                    A_WENC:  wen_q  <= wen_q & ~w1v;
                    A_WENS:  wen_q  <= wen_q | w1v;
                    A_CTRL:  ctrl_q <= merged[2:0];
                    A_DIR:   dir_q  <= merged;
                    A_DOUT:  dout_q <= merged;
                    A_DOUTC: dout_q <= dout_q & ~w1v;
                    A_DOUTS: dout_q <= dout_q | w1v;
                    A_LLO:   llo_q  <= merged;
                    A_LHI:   lhi_q  <= merged;
                    A_RISE:  rise_q <= merged;
                    A_FALL:  fall_q <= merged;
                    A_DBEN:  dben_q <= merged;
                    A_DBT:   dbt_q  <= merged[7:0];
                    default: ;
                endcase
            end
        end
    end

    assign pin_out   = dout_q;
    assign pin_drive = ~dir_q;
    assign irq_a     = |(stat_a & en_a);
    assign irq_b     = |(stat_b & en_b);
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
    import gpb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [LANES-1:0] bus_be,
    input logic [REG_W-1:0] bus_wdata,
    input logic             irq_a,
    input logic             irq_b,
    input logic             wake_req,
    input logic [7:0]       cfg,
    input logic [REG_W-1:0] stat_a,
    input logic [REG_W-1:0] stat_b,
    input logic [REG_W-1:0] dir
);
    assert_en1_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN1 && bus_be == '1 && bus_wdata == '0) |=> !irq_a);

    assert_en2_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN2 && bus_be == '1 && bus_wdata == '0) |=> !irq_b);

    assert_wake_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(cfg[CFG_WKEN] && (cfg[4:3] != 2'b00)));

    assert_inputs_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_a & ~$past(stat_a)) & ~$past(dir)) == '0);

    assert_both_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_a & ~$past(stat_a)) & ~stat_b) == '0);
endmodule

bind gpio_wake_bank gpb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .irq_a(irq_a), .irq_b(irq_b),
    .wake_req(wake_req), .cfg(cfg_q), .stat_a(stat_a), .stat_b(stat_b),
    .dir(dir_q)
);

// File: tb/gpio_wake_bank_bench.sv
module gpio_wake_bank_bench;
    localparam logic [7:0] REV = 8'h21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_drive;
    logic        irq_a, irq_b, wake_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    gpio_wake_bank #(.REVISION(REV)) u_gpio_wake_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_drive(pin_drive),
        .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic setpin(input int idx, input logic v);
        @(negedge clk);
        pin_in[idx] = v;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] bmask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] merge_model(input logic [31:0] old, input logic [31:0] d,
                                                input logic [3:0] be, input logic [31:0] keep);
        return ((old & ~bmask(be)) | (d & bmask(be))) & keep;
    endfunction

    logic [7:0]  ord_addr [12];
    logic [31:0] ord_keep [12];
    logic [31:0] model    [12];

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        ord_addr = '{8'h1C, 8'h20, 8'h2C, 8'h30, 8'h34, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54};
        ord_keep = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h7, 32'hFFFFFFFF, 32'hFFFFFFFF,
                     32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h34, v); check("R1 dir", v, 32'hFFFFFFFF);
        rd(8'h30, v); check("R1 ctrl", v, 32'd2);
        rd(8'h18, v); check("R1 status1", v, 32'd0);
        rd(8'h28, v); check("R1 status2", v, 32'd0);
        rd(8'h1C, v); check("R1 enable1", v, 32'd0);
        rd(8'h44, v); check("R1 hi detect", v, 32'd0);
        rd(8'h14, v); check("R1 sysstatus", v, 32'd1);
        rd(8'h00, v); check("R1 revision", v, {24'd0, REV});
        check("R1 irq/wake", {29'd0, irq_a, irq_b, wake_req}, 32'd0);

        // R3 rising edge sets both status words (R2)
        wr(8'h48, 32'h1, 4'hF);
        setpin(0, 1'b1);
        rd(8'h18, v); check("R3 rise status1", v & 32'h1, 32'h1);
        rd(8'h28, v); check("R2 rise status2", v & 32'h1, 32'h1);
        // R5 clear status1 only
        wr(8'h18, 32'h1, 4'hF);
        rd(8'h18, v); check("R5 cleared status1", v & 32'h1, 32'h0);
        rd(8'h28, v); check("R5 status2 untouched", v & 32'h1, 32'h1);

        // R6 / R7 independent lines, alias set
        wr(8'h74, 32'h1, 4'hF);
        @(negedge clk);
        check("R6 irq_b on", {31'd0, irq_b}, 32'd1);
        check("R6 irq_a off", {31'd0, irq_a}, 32'd0);
        rd(8'h2C, v); check("R7 enable2 via set alias", v, 32'h1);
        rd(8'h70, v); check("R7 alias reads base", v, 32'h1);
        wr(8'h1C, 32'h1, 4'hF);
        @(negedge clk);
        check("R6 irq_a follows cleared status1", {31'd0, irq_a}, 32'd0);
        wr(8'h28, 32'h1, 4'hF);
        @(negedge clk);
        check("R6 irq_b drops after clear", {31'd0, irq_b}, 32'd0);

        // R3 falling edge
        wr(8'h4C, 32'h2, 4'hF);
        setpin(1, 1'b1);
        rd(8'h18, v); check("R3 no fall event on rise", v & 32'h2, 32'h0);
        setpin(1, 1'b0);
        rd(8'h18, v); check("R3 fall event", v & 32'h2, 32'h2);

        // R2 output pin ignored
        wr(8'h34, 32'hFFFFFFFB, 4'hF);
        wr(8'h48, 32'h5, 4'hF);
        setpin(2, 1'b1);
        rd(8'h18, v); check("R2 output pin no event", v & 32'h4, 32'h0);
        check("R11 drive", pin_drive, 32'h4);

        // R4 level re-latch
        wr(8'h44, 32'h8, 4'hF);
        setpin(3, 1'b1);
        rd(8'h18, v); check("R4 high level", v & 32'h8, 32'h8);
        wr(8'h18, 32'h8, 4'hF);
        rd(8'h18, v); check("R4 re-latch", v & 32'h8, 32'h8);
        setpin(3, 1'b0);
        wr(8'h18, 32'h8, 4'hF);
        rd(8'h18, v); check("R4 clear after level gone", v & 32'h8, 32'h0);

        // R8 wakeup qualification
        wr(8'h84, 32'h10, 4'hF);
        wr(8'h48, 32'h15, 4'hF);
        wr(8'h10, 32'h04, 4'hF);
        setpin(4, 1'b1);
        check("R8 no wake with idle 0", {31'd0, wake_req}, 32'd0);
        setpin(4, 1'b0);
        wr(8'h10, 32'h0C, 4'hF);
        setpin(4, 1'b1);
        check("R8 wake pulse", {31'd0, wake_req}, 32'd1);
        @(negedge clk);
        check("R8 wake one cycle", {31'd0, wake_req}, 32'd0);
        rd(8'h20, v); check("R7 wake set alias", v, 32'h10);

        // R10 merge vs no merge
        wr(8'h50, 32'hAABBCCDD, 4'hF);
        wr(8'h50, 32'h11223344, 4'b0100);
        rd(8'h50, v); check("R10 lane merge", v, 32'hAA22CCDD);
        wr(8'h64, 32'h200, 4'hF);
        wr(8'h60, 32'hFFFFFFFF, 4'b0001);
        rd(8'h1C, v); check("R10 clear alias lane only", v, 32'h200);

        // R11 data out aliases and read-only
        wr(8'h3C, 32'hF0, 4'hF);
        wr(8'h94, 32'h1, 4'hF);
        wr(8'h90, 32'h10, 4'hF);
        @(negedge clk);
        check("R11 pin_out", pin_out, 32'hE1);
        wr(8'h00, 32'hFFFFFFFF, 4'hF);
        rd(8'h00, v); check("R11 revision read-only", v, {24'd0, REV});
        wr(8'h38, 32'hFFFFFFFF, 4'hF);
        rd(8'h38, v); check("R11 data in", v, 32'h15);

        // R12 field widths
        wr(8'h30, 32'hFF, 4'hF);
        rd(8'h30, v); check("R12 ctrl 3 bits", v, 32'h7);
        wr(8'h54, 32'h1234, 4'hF);
        rd(8'h54, v); check("R12 debounce time 8 bits", v, 32'h34);

        // R9 soft reset
        wr(8'h10, 32'h1F, 4'hF);
        rd(8'h10, v); check("R9 cfg stored", v, 32'h1D);
        rd(8'h1C, v); check("R9 enable1 cleared", v, 32'h0);
        rd(8'h34, v); check("R9 dir", v, 32'hFFFFFFFF);
        rd(8'h30, v); check("R9 ctrl", v, 32'h2);
        rd(8'h18, v); check("R9 status", v, 32'h0);
        check("R9 data out kept", pin_out, 32'hE1);

        // R10 / R12 random ordinary-register traffic
        for (int i = 0; i < 12; i++) rd(ord_addr[i], model[i]);
        for (int n = 0; n < 150; n++) begin
            int k;
            logic [31:0] d;
            logic [3:0]  be;
            k  = int'($urandom_range(11, 0));
            d  = $urandom;
            be = 4'($urandom_range(15, 0));
            if (n % 10 == 0) be = 4'hF;
            wr(ord_addr[k], d, be);
            model[k] = merge_model(model[k], d, be, ord_keep[k]);
            rd(ord_addr[k], v);
            check("R10 random merge", v, model[k]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule